// File: doc/BRIEF.md
# Six-Channel TDM Audio Serializer

This block packs six parallel 24-bit audio samples into one time-division multiplexed serial stream. It generates its own TDM bit clock from a bit-clock enable that pulses at twice the bit rate, so one bit period lasts two enable pulses. It also drives a frame-sync level and the serial data line. A frame is 256 bit periods long, which is 256 times the sample rate. The frame is cut into eight 32-bit slots. Slots 0 to 5 carry audio and slots 6 and 7 stay silent. Slot 0 feeds the downstream DAC channel 1, slot 1 feeds channel 2, and so on.

A per-slot channel-select map chooses which input channel each slot carries. The six samples and the map are captured together once per frame, on the last rising bit-clock edge before slot 0, so a frame never mixes data from two sample periods. Inside a slot the data is I2S-like. The first bit period is idle, then the MSB follows, then the remaining bits down to bit 0, then zero padding. Data and frame sync change only on falling bit-clock edges, so a receiver can sample on rising edges.

Top module: `tdm6_serializer`

## Requirements
- R1: During and after reset `tdm_bclk` and `tdm_dout` are low and `tdm_fs` is high. After reset, `tdm_bclk` inverts on every clock cycle in which `bclk_tick` is high and holds otherwise.
- R2: A frame is 256 bit periods numbered 0 to 255. Bit 0 is the first bit period after `tdm_fs` falls. `tdm_fs` is low for bits 0 to 127 and high for bits 128 to 255.
- R3: For slot k from 0 to 5, covering bits 32k to 32k+31, bit positions 1 to 24 carry the selected 24-bit sample. Bit 23 (the MSB) is sent at position 1 and bit 0 at position 24.
- R4: `tdm_dout` and `tdm_fs` change only in a cycle where `tdm_bclk` falls.
- R5: Position 0 of every slot, and positions 25 to 31, are driven low.
- R6: Slots 6 and 7 (bits 192 to 255) are driven low.
- R7: The field `slot_map[3k+2:3k]` selects which input channel c feeds slot k. Channel c is `ch_data[24c+23:24c]`. Several slots may select the same channel. The values 6 and 7 make the slot silent.
- R8: `ch_data` and `slot_map` are sampled together on the rising `tdm_bclk` edge of bit 255. The captured values are serialized in the next frame. Input changes at any other time have no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_tick | input | 1 | Half-bit enable; each pulse toggles the bit clock |
| ch_data | input | 144 | Six 24-bit channel samples, channel c at bits 24c+23:24c |
| slot_map | input | 18 | Six 3-bit channel selects, slot k at bits 3k+2:3k |
| tdm_bclk | output | 1 | TDM bit clock |
| tdm_fs | output | 1 | TDM frame sync level |
| tdm_dout | output | 1 | TDM serial data |

## Verification
Two things happen in the same clock cycle: the frame capture fires on the rising bit-clock edge of bit 255, and the bit clock itself toggles in that cycle. The bench changes `ch_data` and `slot_map` at two points: in the middle of a frame, and right after bit 254, only a few ticks before the capture. It then checks every received bit against a snapshot it takes itself at the capture edge. A mid-frame change must leave the current frame untouched. A late change must appear in full in the next frame. The tick pattern is random, so the capture edge lands after gaps of different lengths.

// File: rtl/tdm6_serializer.sv
module tdm6_serializer #(
  parameter int NCH    = 6,
  parameter int SW     = 24,
  parameter int SLOT_W = 32,
  parameter int SLOTS  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bclk_tick,
  input  logic [NCH*SW-1:0]          ch_data,
  input  logic [NCH*$clog2(NCH)-1:0] slot_map,
  output logic                       tdm_bclk,
  output logic                       tdm_fs,
  output logic                       tdm_dout
);
  localparam int FRAME = SLOTS * SLOT_W;
  localparam int CW    = $clog2(FRAME);
  localparam int PW    = $clog2(SLOT_W);
  localparam int SELW  = $clog2(NCH);

  logic [CW-1:0]   bitc;
  logic            bclk_q;
  logic [SW-1:0]   lat   [NCH];
  logic [SELW-1:0] map_q [NCH];

  wire fall    = bclk_tick &  bclk_q;
  wire rise    = bclk_tick & ~bclk_q;
  wire capture = rise && (bitc == CW'(FRAME - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      bitc   <= CW'(FRAME - 1);
    end else begin
      if (bclk_tick) bclk_q <= ~bclk_q;
      if (fall)      bitc   <= bitc + 1'b1;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lat[g]   <= '0;
        map_q[g] <= SELW'(g);
      end else if (capture) begin
        lat[g]   <= ch_data[g*SW +: SW];
        map_q[g] <= slot_map[g*SELW +: SELW];
      end
    end
  end

  wire [CW-PW-1:0] slot = bitc[CW-1:PW];
  wire [PW-1:0]    pos  = bitc[PW-1:0];

  logic [SELW-1:0] cur_sel;
  logic [SW-1:0]   word;
  logic [SW-1:0]   shifted;
  logic            active;

  always_comb begin
    cur_sel = '1;
    for (int k = 0; k < NCH; k++)
      if (int'(slot) == k) cur_sel = map_q[k];
    word = '0;
    for (int k = 0; k < NCH; k++)
      if (int'(cur_sel) == k) word = lat[k];
    active  = (int'(slot) < NCH) && (pos != '0) && (int'(pos) <= SW)
              && (int'(cur_sel) < NCH);
    shifted = word << (pos - 1'b1);
  end

  assign tdm_bclk = bclk_q;
  assign tdm_fs   = bitc[CW-1];
  assign tdm_dout = active & shifted[SW-1];
endmodule

module tdm6_serializer_chk #(
  parameter int NCH    = 6,
  parameter int SLOT_W = 32,
  parameter int CW     = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bclk_tick,
  input logic          tdm_bclk,
  input logic          tdm_fs,
  input logic          tdm_dout,
  input logic [CW-1:0] bitc
);
  localparam int PW = $clog2(SLOT_W);

  a_r1_bclk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_tick |=> $stable(tdm_bclk));
  a_r1_bclk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_tick |=> (tdm_bclk != $past(tdm_bclk)));
  a_r4_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(tdm_bclk) |-> ($stable(tdm_fs) && $stable(tdm_dout)));
  a_r2_fs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tdm_fs) |-> (bitc == CW'(1 << (CW - 1))));
  a_r2_fs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tdm_fs) |-> (bitc == '0));
  a_r5_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bitc[PW-1:0] == '0) |-> !tdm_dout);
  a_r6_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bitc[CW-1:PW]) >= NCH) |-> !tdm_dout);
endmodule

bind tdm6_serializer tdm6_serializer_chk #(.NCH(NCH), .SLOT_W(SLOT_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .tdm_bclk(tdm_bclk),
  .tdm_fs(tdm_fs), .tdm_dout(tdm_dout), .bitc(bitc)
);

// File: tb/tdm6_serializer_tb.sv
module tdm6_serializer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk_tick = 1'b0;
  logic [143:0] ch_data;
  logic [17:0]  slot_map;
  logic tdm_bclk, tdm_fs, tdm_dout;

  always #2.5 clk = ~clk;

  tdm6_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick), .ch_data(ch_data),
    .slot_map(slot_map), .tdm_bclk(tdm_bclk), .tdm_fs(tdm_fs), .tdm_dout(tdm_dout)
  );

  logic [23:0] smp [6];
  logic [2:0]  mp  [6];
  logic [23:0] snap_smp [6];
  logic [2:0]  snap_mp  [6];
  int checks = 0, fails = 0;
  int bidx = 255, frames = 0;
  logic exp_bclk = 1'b0, prev_bclk = 1'b0, running = 1'b0, done = 1'b0;

  always_comb begin
    for (int c = 0; c < 6; c++) begin
      ch_data[c*24 +: 24] = smp[c];
      slot_map[c*3 +: 3]  = mp[c];
    end
  end

  task automatic chk(input string req, input int bit_no, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s bit %0d frame %0d: got %b exp %b", req, bit_no, frames, got, exp);
    end
  endtask

  function automatic logic exp_bit(input int b);
    int s = b / 32, p = b % 32;
    if (s >= 6 || p == 0 || p > 24) return 1'b0;
    if (snap_mp[s] >= 3'd6) return 1'b0;
    return snap_smp[snap_mp[s]][24 - p];
  endfunction

  function automatic string req_of(input int b);
    int p = b % 32;
    if (b >= 192) return "R6";
    if (p == 0 || p > 24) return "R5";
    return "R3/R7/R8";
  endfunction

  task automatic new_stim(input int nf);
    for (int c = 0; c < 6; c++) begin
      case (nf)
        2: begin smp[c] = $urandom(); mp[c] = (c == 0) ? 3'd6 : 3'd7; end
        3: begin smp[c] = 24'hFFFFFF; mp[c] = 3'(c); end
        4: begin smp[c] = (c % 2 == 0) ? 24'h800000 : 24'h000001; mp[c] = 3'd2; end
        5: begin smp[c] = 24'hA5A5A5 ^ 24'(c); mp[c] = 3'(5 - c); end
        default: begin smp[c] = $urandom(); mp[c] = 3'($urandom_range(0, 7)); end
      endcase
    end
  endtask

  always @(negedge clk) begin
    if (running && !done) begin
      exp_bclk = exp_bclk ^ bclk_tick;
      chk("R1", bidx, tdm_bclk, exp_bclk);
      if (tdm_bclk && !prev_bclk) begin
        if (bidx == 255)
          for (int c = 0; c < 6; c++) begin snap_smp[c] = smp[c]; snap_mp[c] = mp[c]; end
        chk("R2", bidx, tdm_fs, (bidx >= 128));
        chk(req_of(bidx), bidx, tdm_dout, exp_bit(bidx));
        if ((bidx == 100 && frames % 2 == 0) || (bidx == 254 && frames % 2 == 1))
          new_stim(frames + 1);
        if (bidx == 255) begin
          frames++;
          bidx = 0;
          if (frames == 13) done = 1'b1;
        end else bidx++;
      end
      prev_bclk = tdm_bclk;
      bclk_tick <= ($urandom_range(0, 3) != 0);
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < 6; c++) begin smp[c] = $urandom(); mp[c] = 3'(c); end
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", 255, tdm_bclk, 1'b0);
    chk("R1", 255, tdm_fs, 1'b1);
    chk("R1", 255, tdm_dout, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 255, tdm_fs, 1'b1);
    running = 1'b1;
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule